// File: doc/BRIEF.md
# System Clock Mode Switch Controller

This block picks the rate of the core's phi clock from one of four speed modes: low, middle, high and double. Software selects a mode with a plain write to an 8-bit mode register on a simple register bus. The block then produces a phi clock-enable pulse train on the fast reference clock, or follows the slow clock's ticks when in low-speed mode.

Every request is checked against the allowed transitions. A jump from low straight to double is refused and recorded in a sticky error flag. Leaving low-speed mode does not take effect at once. The block raises a busy flag and waits until a slow-clock tick arrives, so that the new clock starts on a known phase. The wait always lasts at least one and at most four machine cycles. The other transitions take effect on the next clock edge.

A machine cycle is one phi period in high-speed mode, which is two reference clock cycles.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the mode field holds middle-speed, busy reads 0 and the error flag reads 0.
- R2: The register sits at bus address 0x3B. The read layout is: bits [1:0] hold the mode (00 middle, 01 high, 10 low, 11 double), bit 6 holds the sticky error flag, bit 7 holds busy, and the other bits read 0. A read at any other address returns 0, and a write to any other address changes nothing.
- R3: A legal request whose current mode is not low takes effect at the clock edge that accepts the write. Busy stays 0.
- R4: A request from low to double is refused. The mode stays low, and the error flag sets and stays set until reset.
- R5: A request from low to another mode raises busy. The new mode commits at the first edge where a slow tick is present and at least 2 reference cycles (1 machine cycle) have passed. If no such tick arrives, the mode commits at 8 cycles (4 machine cycles).
- R6: A mode write accepted while busy is 1 is dropped entirely. It changes neither the pending mode nor the error flag.
- R7: phi enable pulses on every cycle in double, on every 2nd cycle in high and on every 8th cycle in middle. In low it equals the slow tick input.
- R8: Writing the current mode is a no-op with no error. Middle to double is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| slow_tick_i | input | 1 | Synchronised slow-clock tick, one cycle wide |
| phi_en_o | output | 1 | Core phi clock enable |
| mode_o | output | 2 | Active mode / divider select |
| busy_o | output | 1 | Switch wait in progress |

## Verification
The bench places the slow tick at several offsets after a switch out of low-speed mode. These are: no tick at all, a tick too early to count, a tick at the earliest legal cycle, a tick in the middle of the window and a tick at the deadline. A design with a wrong wait counter would commit too early, stall beyond four machine cycles, or ignore the tick. The bench also issues a forbidden low-to-double request and a write during the busy window. A design that leaked either one would change mode, or would leave the error flag clear or wrongly set. Finally the bench counts phi pulses in every mode, to catch a divider that selects the wrong ratio.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
  typedef enum logic [1:0] {
    M_MID  = 2'b00,
    M_HIGH = 2'b01,
    M_LOW  = 2'b10,
    M_DBL  = 2'b11
  } mode_e;

  // only the direct slow-to-double jump is forbidden
  function automatic logic trans_ok(mode_e from_m, mode_e to_m);
    return !(from_m == M_LOW && to_m == M_DBL);
  endfunction
endpackage

// File: rtl/clk_switch_wait.sv
module clk_switch_wait #(
  parameter int MIN_CYC = 2,
  parameter int MAX_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic commit_o
);
  localparam int CW = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] elapsed;
  logic          busy_q;

  assign elapsed  = cnt_q + 1'b1;
  assign commit_o = busy_q & ((tick_i & (elapsed >= CW'(MIN_CYC))) |
                              (elapsed == CW'(MAX_CYC)));
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (commit_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= elapsed;
    end
  end

  p_wait_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q < CW'(MAX_CYC)));
  p_start_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);
endmodule

// File: rtl/clk_mode_reg.sv
module clk_mode_reg
  import clk_mode_pkg::*;
#(
  parameter int          AW        = 8,
  parameter logic [AW-1:0] MODE_ADDR = 8'h3B
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          busy_i,
  input  logic          commit_i,
  output mode_e         mode_o,
  output logic          err_o,
  output logic          start_o
);
  mode_e cur_q, pend_q, req;
  logic  err_q, accept, legal;

  assign req     = mode_e'(wdata_i[1:0]);
  assign accept  = we_i & (addr_i == MODE_ADDR) & ~busy_i;
  assign legal   = trans_ok(cur_q, req);
  assign start_o = accept & legal & (cur_q == M_LOW) & (req != M_LOW);
  assign mode_o  = cur_q;
  assign err_o   = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= M_MID;
      pend_q <= M_MID;
      err_q  <= 1'b0;
    end else begin
      if (accept) begin
        if (!legal)       err_q  <= 1'b1;
        else if (start_o) pend_q <= req;
        else              cur_q  <= req;
      end
      if (commit_i) cur_q <= pend_q;
    end
  end

  p_no_low_dbl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == M_LOW) |=> (cur_q != M_DBL));
  p_err_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_hold_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !commit_i) |=> $stable(cur_q));
endmodule

// File: rtl/clk_phi_div.sv
module clk_phi_div
  import clk_mode_pkg::*;
#(
  parameter int HIGH_DIV = 2,
  parameter int MID_DIV  = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  slow_tick_i,
  output logic  phi_en_o
);
  localparam int DW = (MID_DIV > 1) ? $clog2(MID_DIV) : 1;
  localparam int HW = (HIGH_DIV > 1) ? $clog2(HIGH_DIV) : 1;

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  always_comb begin
    unique case (mode_i)
      M_DBL:   phi_en_o = 1'b1;
      M_HIGH:  phi_en_o = (div_q[HW-1:0] == '0);
      M_MID:   phi_en_o = (div_q == '0);
      default: phi_en_o = slow_tick_i;
    endcase
  end

  p_mid_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_MID && phi_en_o && $stable(mode_i)) |=> !phi_en_o);
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int            AW        = 8,
  parameter logic [AW-1:0] MODE_ADDR = 8'h3B,
  parameter int            HIGH_DIV  = 2,
  parameter int            MID_DIV   = 8,
  parameter int            MIN_MC    = 1,
  parameter int            MAX_MC    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  input  logic          slow_tick_i,
  output logic          phi_en_o,
  output logic [1:0]    mode_o,
  output logic          busy_o
);
  localparam int MIN_CYC = MIN_MC * HIGH_DIV;
  localparam int MAX_CYC = MAX_MC * HIGH_DIV;

  mode_e mode;
  logic  err, start, commit, busy;

  clk_mode_reg #(.AW(AW), .MODE_ADDR(MODE_ADDR)) u_reg (
    .clk_i, .rst_ni,
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .busy_i   (busy),
    .commit_i (commit),
    .mode_o   (mode),
    .err_o    (err),
    .start_o  (start)
  );

  clk_switch_wait #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)) u_wait (
    .clk_i, .rst_ni,
    .start_i  (start),
    .tick_i   (slow_tick_i),
    .busy_o   (busy),
    .commit_o (commit)
  );

  clk_phi_div #(.HIGH_DIV(HIGH_DIV), .MID_DIV(MID_DIV)) u_div (
    .clk_i, .rst_ni,
    .mode_i      (mode),
    .slow_tick_i (slow_tick_i),
    .phi_en_o    (phi_en_o)
  );

  assign bus_rdata_o = (bus_addr_i == MODE_ADDR) ? {busy, err, 4'b0000, mode} : 8'h00;
  assign mode_o      = mode;
  assign busy_o      = busy;
endmodule

// File: tb/clk_mode_ctrl_bench.sv
`timescale 1ns/1ps
module clk_mode_ctrl_bench;
  logic       clk = 0, rst_n = 0, we = 0, tick = 0;
  logic [7:0] addr = 8'h3B, wdata = 0, rdata;
  logic       phi_en, busy;
  logic [1:0] mode;
  int nchk = 0, nfail = 0;

  localparam logic [1:0] MID = 2'b00, HIGH = 2'b01, LOW = 2'b10, DBL = 2'b11;

  always #2.5 clk = ~clk;

  clk_mode_ctrl u_clk_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .slow_tick_i(tick),
    .phi_en_o(phi_en), .mode_o(mode), .busy_o(busy)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = 8'h3B; #1;
  endtask

  task automatic t_reset;
    #1;
    chk(rdata == 8'h00, "R1 reset rdata", rdata, 8'h00);
    chk(mode == MID && !busy, "R1 reset mode", {busy, mode}, MID);
  endtask

  task automatic t_addr;
    wr(8'h3A, {6'd0, HIGH});
    chk(mode == MID, "R2 wrong addr write", mode, MID);
    addr = 8'h3A; #1;
    chk(rdata == 8'h00, "R2 wrong addr read", rdata, 0);
    addr = 8'h3B; #1;
    chk(rdata == {6'd0, MID}, "R2 layout", rdata, MID);
  endtask

  task automatic t_immediate(input logic [1:0] m, input string req);
    wr(8'h3B, {6'd0, m});
    chk(mode == m && !busy, req, {busy, mode}, m);
    chk(rdata == {6'd0, m}, {req, " rdata"}, rdata, m);
  endtask

  task automatic t_leave_low(input logic [1:0] tgt, input int k);
    int exp_c, c;
    exp_c = (k >= 2 && k <= 8) ? k : 8;
    c = 0;
    @(negedge clk); we = 1; wdata = {6'd0, tgt};
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk); we = 0; #0.5;
      if (busy) begin
        c++;
        chk(mode == LOW, "R5 mode held while busy", mode, LOW);
        chk(rdata[7] == 1'b1, "R2 busy bit", rdata, 8'h80);
      end
      tick = (j == k);
    end
    tick = 0; #1;
    chk(c == exp_c, "R5 wait length", c, exp_c);
    chk(c >= 2 && c <= 8, "R5 window 1..4 machine cycles", c, 2);
    chk(mode == tgt && !busy, "R5 committed mode", mode, tgt);
  endtask

  task automatic t_busy_ignore;
    logic e0;
    e0 = rdata[6];
    @(negedge clk); we = 1; wdata = {6'd0, MID};
    @(negedge clk); we = 0;
    @(negedge clk); we = 1; wdata = {6'd0, DBL};
    @(negedge clk); we = 0;
    repeat (10) @(negedge clk);
    #1;
    chk(mode == MID, "R6 write during busy dropped", mode, MID);
    chk(rdata[6] == e0, "R6 error untouched", rdata[6], e0);
  endtask

  task automatic t_rate(input logic [1:0] m, input int exp);
    int n;
    n = 0;
    if (mode != m) wr(8'h3B, {6'd0, m});
    for (int j = 0; j < 32; j++) begin
      @(negedge clk);
      tick = (m == LOW) && (j % 3 == 0); #0.5;
      if (phi_en) n++;
    end
    tick = 0;
    chk(n == exp, "R7 phi rate", n, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_addr();
    t_immediate(MID, "R8 same mode no-op");
    chk(rdata[6] == 0, "R8 no error", rdata[6], 0);
    t_immediate(HIGH, "R3 mid->high");
    t_immediate(DBL, "R3 high->dbl");
    t_immediate(MID, "R3 dbl->mid");
    t_immediate(DBL, "R8 mid->dbl legal");
    t_immediate(LOW, "R3 dbl->low");
    t_leave_low(HIGH, 0);
    t_immediate(LOW, "R3 high->low");
    t_leave_low(MID, 1);
    t_immediate(LOW, "R3 mid->low");
    t_leave_low(HIGH, 2);
    t_immediate(LOW, "R3 high->low");
    t_leave_low(MID, 5);
    t_immediate(LOW, "R3 mid->low");
    t_leave_low(HIGH, 8);
    t_immediate(LOW, "R3 high->low");
    t_busy_ignore();
    t_immediate(LOW, "R3 mid->low");
    wr(8'h3B, {6'd0, DBL});
    chk(mode == LOW, "R4 low->dbl refused", mode, LOW);
    chk(rdata == 8'h42, "R4 error flag set", rdata, 8'h42);
    t_leave_low(HIGH, 3);
    chk(rdata[6] == 1, "R4 error sticky", rdata[6], 1);
    t_rate(DBL, 32);
    t_rate(HIGH, 16);
    t_rate(MID, 4);
    t_rate(LOW, 11);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule